// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block drives an 8-bit asynchronous parallel NOR flash. A host raises a one-cycle request carrying an operation code, a target address and a data byte. The sequencer then emits the unlock and command write cycles the device expects, polls the device until the operation has finished, and returns the device to read mode. Each access to the flash is a single strobed cycle with chip-enable held low. The strobe width and the idle turnaround between accesses are set by parameters.

Four operations exist: plain read, byte program, sector erase and return-to-read. A program is finished when the byte read back equals the byte written. An erase is finished when bit 7 of the byte read from the sector address is 1. If completion is never seen, a bounded poll count ends the operation and flags an error. The block then still writes the return-to-read command.

Top module: `nor_cmd_seq`

## Requirements
- R1: Out of reset, busy_o, done_o, err_o and flash_dq_oe_o are 0. flash_ce_no, flash_we_no and flash_oe_no are 1.
- R2: Op code 1 (program) produces exactly these writes, in this order: 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, data@target, 0xF0@0x000.
- R3: Op code 2 (sector erase) produces exactly these writes, in this order: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x30@target, 0xF0@0x000.
- R4: Op code 3 (return-to-read) produces a single write of 0xF0 to address 0x000 and performs no reads.
- R5: Op code 0 (read) performs exactly one read access at the target address and no writes. rdata_o then holds the byte the device returned.
- R6: Every write-enable or output-enable low pulse lasts exactly STROBE_CLKS clocks. Chip-enable is low during it. Write-enable and output-enable are never low together.
- R7: Between two accesses, chip-enable stays high for at least GAP_CLKS clocks. Address and write data hold steady while chip-enable is low.
- R8: After the program command, the target address is read repeatedly until the byte read equals the data byte. The number of reads is the number of busy reads plus one.
- R9: After the erase command, the sector address is read repeatedly until bit 7 of the byte read is 1. Other bits are ignored.
- R10: If POLL_MAX consecutive polls all fail, polling stops and err_o goes to 1. The 0xF0 write still follows. After a successful operation err_o is 0.
- R11: busy_o is 1 from the cycle after a request is accepted through the cycle in which done_o pulses. done_o lasts exactly one clock. A request raised while busy_o is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, accepted while idle |
| op_i | input | 2 | 0 read, 1 program, 2 sector erase, 3 return-to-read |
| addr_i | input | AW | Target or sector address |
| wdata_i | input | 8 | Byte to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Poll timeout seen in the last operation |
| rdata_o | output | 8 | Byte returned by the last read operation |
| flash_ce_no | output | 1 | Chip enable, active low |
| flash_we_no | output | 1 | Write enable, active low |
| flash_oe_no | output | 1 | Output enable, active low |
| flash_addr_o | output | AW | Flash address |
| flash_dq_o | output | 8 | Data driven to the flash |
| flash_dq_oe_o | output | 1 | Drive enable for flash_dq_o |
| flash_dq_i | input | 8 | Data returned by the flash |

## Verification
The bench targets four boundaries:
- Poll counts of POLL_MAX-1 and POLL_MAX. A poll counter that is off by one would either flag a successful operation or poll once too often.
- An erase busy status of 0x7F. A decoder that compares the whole byte, or the wrong bit, would finish early or never finish.
- A second request raised in the middle of an operation. A design that accepted it would add an extra write cycle or an extra done pulse.
- Strobe pulses and gaps measured on every access. A counter that is off by one would show up as a 9- or 11-clock strobe, or as a gap that is too short.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_RDMODE = 2'd3} op_e;
  typedef enum logic [1:0] {ST_WR, ST_RD, ST_POLL, ST_END} step_kind_e;
  localparam logic [7:0] CMD_KEY1    = 8'hAA;
  localparam logic [7:0] CMD_KEY2    = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERSETUP = 8'h80;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_RDMODE  = 8'hF0;
  localparam logic [11:0] ADDR_KEY1  = 12'h555;
  localparam logic [11:0] ADDR_KEY2  = 12'h2AA;
endpackage

// File: rtl/nor_cmd_steps.sv
module nor_cmd_steps import nor_seq_pkg::*; #(
  parameter int AW = 12
) (
  input  op_e           op_i,
  input  logic [3:0]    idx_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [7:0]    tgt_data_i,
  output step_kind_e    kind_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o
);
  localparam logic [AW-1:0] A_K1 = AW'(ADDR_KEY1);
  localparam logic [AW-1:0] A_K2 = AW'(ADDR_KEY2);

  always_comb begin
    kind_o = ST_END;
    addr_o = '0;
    data_o = CMD_RDMODE;
    unique case (op_i)
      OP_READ: if (idx_i == 4'd0) begin kind_o = ST_RD; addr_o = tgt_addr_i; end
      OP_RDMODE: if (idx_i == 4'd0) kind_o = ST_WR;
      OP_PROG: begin
        unique case (idx_i)
          4'd0: begin kind_o = ST_WR; addr_o = A_K1; data_o = CMD_KEY1; end
          4'd1: begin kind_o = ST_WR; addr_o = A_K2; data_o = CMD_KEY2; end
          4'd2: begin kind_o = ST_WR; addr_o = A_K1; data_o = CMD_PROG; end
          4'd3: begin kind_o = ST_WR; addr_o = tgt_addr_i; data_o = tgt_data_i; end
          4'd4: begin kind_o = ST_POLL; addr_o = tgt_addr_i; end
          4'd5: kind_o = ST_WR;
          default: kind_o = ST_END;
        endcase
      end
      OP_ERASE: begin
        unique case (idx_i)
          4'd0, 4'd3: begin kind_o = ST_WR; addr_o = A_K1; data_o = CMD_KEY1; end
          4'd1, 4'd4: begin kind_o = ST_WR; addr_o = A_K2; data_o = CMD_KEY2; end
          4'd2: begin kind_o = ST_WR; addr_o = A_K1; data_o = CMD_ERSETUP; end
          4'd5: begin kind_o = ST_WR; addr_o = tgt_addr_i; data_o = CMD_SECTOR; end
          4'd6: begin kind_o = ST_POLL; addr_o = tgt_addr_i; end
          4'd7: kind_o = ST_WR;
          default: kind_o = ST_END;
        endcase
      end
      default: kind_o = ST_END;
    endcase
  end
endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int AW          = 12,
  parameter int STROBE_CLKS = 10,
  parameter int GAP_CLKS    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          ready_o,
  output logic          ack_o,
  output logic [7:0]    rdata_o,
  output logic          ce_no,
  output logic          we_no,
  output logic          oe_no,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    dq_o,
  output logic          dq_oe_o,
  input  logic [7:0]    dq_i
);
  localparam int MAXC = (STROBE_CLKS > GAP_CLKS) ? STROBE_CLKS : GAP_CLKS;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_STROBE, PH_GAP} phase_e;
  phase_e          phase_q;
  logic [CW-1:0]   cnt_q;
  logic            wr_q;

  // ready on the last gap clock so back-to-back accesses keep exactly GAP_CLKS
  assign ready_o = (phase_q == PH_IDLE) || (phase_q == PH_GAP && cnt_q == '0);
  assign ack_o   = (phase_q == PH_STROBE) && (cnt_q == '0);
  assign rdata_o = dq_i;
  assign ce_no   = (phase_q != PH_STROBE);
  assign we_no   = !((phase_q == PH_STROBE) && wr_q);
  assign oe_no   = !((phase_q == PH_STROBE) && !wr_q);
  assign dq_oe_o = (phase_q != PH_IDLE) && wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_o  <= '0;
      dq_o    <= '0;
    end else if (start_i && ready_o) begin
      phase_q <= PH_STROBE;
      cnt_q   <= CW'(STROBE_CLKS - 1);
      wr_q    <= wr_i;
      addr_o  <= addr_i;
      dq_o    <= data_i;
    end else begin
      unique case (phase_q)
        PH_STROBE: begin
          if (cnt_q == '0) begin
            phase_q <= PH_GAP;
            cnt_q   <= CW'(GAP_CLKS - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_GAP: begin
          if (cnt_q == '0) begin
            phase_q <= PH_IDLE;
            wr_q    <= 1'b0;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq import nor_seq_pkg::*; #(
  parameter int AW          = 12,
  parameter int STROBE_CLKS = 10,
  parameter int GAP_CLKS    = 2,
  parameter int POLL_MAX    = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [7:0]    rdata_o,
  output logic          flash_ce_no,
  output logic          flash_we_no,
  output logic          flash_oe_no,
  output logic [AW-1:0] flash_addr_o,
  output logic [7:0]    flash_dq_o,
  output logic          flash_dq_oe_o,
  input  logic [7:0]    flash_dq_i
);
  localparam int PCW = $clog2(POLL_MAX) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;
  state_e        state_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q, rdata_q;
  logic [3:0]    idx_q;
  logic [PCW-1:0] poll_q;
  logic          err_q;

  step_kind_e    kind;
  logic [AW-1:0] step_addr;
  logic [7:0]    step_data;
  logic          bus_ready, bus_ack, bus_start, poll_hit;
  logic [7:0]    bus_rdata;

  nor_cmd_steps #(.AW(AW)) u_steps (
    .op_i(op_q), .idx_i(idx_q), .tgt_addr_i(addr_q), .tgt_data_i(data_q),
    .kind_o(kind), .addr_o(step_addr), .data_o(step_data)
  );

  assign bus_start = (state_q == S_ISSUE) && (kind != ST_END);

  nor_bus_cycle #(.AW(AW), .STROBE_CLKS(STROBE_CLKS), .GAP_CLKS(GAP_CLKS)) u_bus (
    .clk_i, .rst_ni,
    .start_i(bus_start), .wr_i(kind == ST_WR), .addr_i(step_addr), .data_i(step_data),
    .ready_o(bus_ready), .ack_o(bus_ack), .rdata_o(bus_rdata),
    .ce_no(flash_ce_no), .we_no(flash_we_no), .oe_no(flash_oe_no),
    .addr_o(flash_addr_o), .dq_o(flash_dq_o), .dq_oe_o(flash_dq_oe_o), .dq_i(flash_dq_i)
  );

  assign poll_hit = (op_q == OP_ERASE) ? bus_rdata[7] : (bus_rdata == data_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      idx_q   <= '0;
      poll_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_i) begin
          op_q    <= op_e'(op_i);
          addr_q  <= addr_i;
          data_q  <= wdata_i;
          idx_q   <= '0;
          poll_q  <= '0;
          err_q   <= 1'b0;
          state_q <= S_ISSUE;
        end
        S_ISSUE: begin
          if (kind == ST_END) state_q <= S_DONE;
          else if (bus_ready) state_q <= S_WAIT;
        end
        S_WAIT: if (bus_ack) begin
          state_q <= S_ISSUE;
          if (kind == ST_POLL) begin
            if (poll_hit) idx_q <= idx_q + 1'b1;
            else if (poll_q == PCW'(POLL_MAX - 1)) begin
              err_q <= 1'b1;
              idx_q <= idx_q + 1'b1;
            end else poll_q <= poll_q + 1'b1;
          end else begin
            if (kind == ST_RD) rdata_q <= bus_rdata;
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_DONE);
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          flash_ce_no,
  input logic          flash_we_no,
  input logic          flash_oe_no,
  input logic [AW-1:0] flash_addr_o,
  input logic [7:0]    flash_dq_o,
  input logic          flash_dq_oe_o
);
  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!flash_we_no && !flash_oe_no));
  assert_ce_covers_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no || !flash_oe_no) |-> !flash_ce_no);
  assert_addr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_ce_no && $past(!flash_ce_no)) |-> $stable(flash_addr_o));
  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no && $past(!flash_we_no)) |-> $stable(flash_dq_o));
  assert_no_drive_on_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_dq_oe_o |-> flash_oe_no);
  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_in_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (flash_we_no && flash_oe_no));
  assert_err_while_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> busy_o);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .flash_ce_no(flash_ce_no), .flash_we_no(flash_we_no), .flash_oe_no(flash_oe_no),
  .flash_addr_o(flash_addr_o), .flash_dq_o(flash_dq_o), .flash_dq_oe_o(flash_dq_oe_o)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
  localparam int AW = 12;
  localparam int STROBE = 10;
  localparam int GAP = 2;
  localparam int PMAX = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] op = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic busy, done, err;
  logic [7:0] rdata;
  logic ce_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] f_addr;
  logic [7:0] dq_o, dq_i;

  always #2 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .STROBE_CLKS(STROBE), .GAP_CLKS(GAP), .POLL_MAX(PMAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .flash_ce_no(ce_n), .flash_we_no(we_n), .flash_oe_no(oe_n), .flash_addr_o(f_addr),
    .flash_dq_o(dq_o), .flash_dq_oe_o(dq_oe), .flash_dq_i(dq_i)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req_tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  // behavioural flash stub
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int busy_reads = 0, pend = 0;
  logic [7:0] pend_st = 8'h00;
  int nreads = 0, nw = 0, bad_width = 0, bad_gap = 0;
  int run_we = 0, run_oe = 0, run_ce = 0;
  bit ce_seen = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [AW-1:0] log_a [16];
  logic [7:0]    log_d [16];
  logic [AW-1:0] h_a [5];
  logic [7:0]    h_d [5];

  assign dq_i = (pend > 0) ? pend_st : mem[f_addr[7:0]];

  function automatic bit hist_is(input int k, input logic [AW-1:0] a, input logic [7:0] d);
    return (h_a[k] == a) && (h_d[k] == d);
  endfunction

  task automatic dev_write(input logic [AW-1:0] a, input logic [7:0] d);
    if (nw < 16) begin log_a[nw] = a; log_d[nw] = d; end
    nw++;
    if (hist_is(2, 12'h555, 8'hAA) && hist_is(3, 12'h2AA, 8'h55) && hist_is(4, 12'h555, 8'hA0)) begin
      mem[a[7:0]] = d; pend = busy_reads; pend_st = ~d;
    end else if (d == 8'h30 && hist_is(0, 12'h555, 8'hAA) && hist_is(1, 12'h2AA, 8'h55) &&
                 hist_is(2, 12'h555, 8'h80) && hist_is(3, 12'h555, 8'hAA) && hist_is(4, 12'h2AA, 8'h55)) begin
      mem[a[7:0]] = 8'hFF; pend = busy_reads; pend_st = 8'h7F;
    end else if (d == 8'hF0) pend = 0;
    for (int k = 0; k < 4; k++) begin h_a[k] = h_a[k+1]; h_d[k] = h_d[k+1]; end
    h_a[4] = a; h_d[4] = d;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) run_we++;
      else if (!prev_we) begin
        if (run_we != STROBE) bad_width++;
        run_we = 0;
        dev_write(f_addr, dq_o);
      end
      if (!oe_n) run_oe++;
      else if (!prev_oe) begin
        if (run_oe != STROBE) bad_width++;
        run_oe = 0;
        nreads++;
        if (pend > 0) pend--;
      end
      if (ce_n) run_ce++;
      else begin
        if (ce_seen && run_ce > 0 && run_ce < GAP) bad_gap++;
        if (run_ce > 0) ce_seen = 1;
        run_ce = 0;
      end
      prev_we = we_n;
      prev_oe = oe_n;
    end
  end

  // expected write list
  logic [AW-1:0] ex_a [16];
  logic [7:0]    ex_d [16];

  function automatic int build_exp(input int o, input logic [AW-1:0] a, input logic [7:0] d);
    int n = 0;
    if (o == 1 || o == 2) begin
      ex_a[0] = 12'h555; ex_d[0] = 8'hAA;
      ex_a[1] = 12'h2AA; ex_d[1] = 8'h55;
      n = 2;
    end
    if (o == 1) begin
      ex_a[2] = 12'h555; ex_d[2] = 8'hA0;
      ex_a[3] = a;       ex_d[3] = d;
      n = 4;
    end
    if (o == 2) begin
      ex_a[2] = 12'h555; ex_d[2] = 8'h80;
      ex_a[3] = 12'h555; ex_d[3] = 8'hAA;
      ex_a[4] = 12'h2AA; ex_d[4] = 8'h55;
      ex_a[5] = a;       ex_d[5] = 8'h30;
      n = 6;
    end
    if (o != 0) begin ex_a[n] = 12'h000; ex_d[n] = 8'hF0; n++; end
    return n;
  endfunction

  function automatic string seq_req(input int o);
    case (o)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_op(input int o, input logic [AW-1:0] a, input logic [7:0] d,
                        input int br, input bit inject);
    int n_exp, exp_reads, cyc, busy_drop, n_done;
    bit exp_err;
    string pr;
    busy_reads = br;
    nw = 0; nreads = 0; bad_width = 0; bad_gap = 0;
    n_exp = build_exp(o, a, d);
    exp_err = (o == 1 || o == 2) && (br >= PMAX);
    if (o == 0) exp_reads = 1;
    else if (o == 3) exp_reads = 0;
    else exp_reads = (br >= PMAX) ? PMAX : br + 1;
    pr = (o == 2) ? "R9" : "R8";
    @(negedge clk);
    req = 1'b1; op = 2'(o); addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R11", "busy after accept", busy, 1);
    cyc = 0; busy_drop = 0; n_done = 0;
    while (!done && cyc < 5000) begin
      if (inject && cyc == 5) begin req = 1'b1; op = 2'd3; addr = 12'h0AB; end
      else req = 1'b0;
      @(negedge clk);
      cyc++;
      if (!busy) busy_drop++;
    end
    req = 1'b0;
    chk(cyc < 5000, "R11", "done reached", cyc, 0);
    chk(busy_drop == 0, "R11", "busy held until done", busy_drop, 0);
    @(negedge clk);
    chk(!done && !busy, "R11", "done one cycle then idle", {done, busy}, 0);
    repeat (GAP + 4) begin
      @(negedge clk);
      if (done) n_done++;
    end
    chk(n_done == 0 && !busy, "R11", "no extra operation started", n_done, 0);
    chk(nw == n_exp, seq_req(o), "write count", nw, n_exp);
    for (int k = 0; k < n_exp && k < nw; k++)
      chk(log_a[k] == ex_a[k] && log_d[k] == ex_d[k], seq_req(o), "write entry",
          {log_a[k], log_d[k]}, {ex_a[k], ex_d[k]});
    if (o == 1 || o == 2) chk(nreads == exp_reads, pr, "poll read count", nreads, exp_reads);
    else chk(nreads == exp_reads, seq_req(o), "read count", nreads, exp_reads);
    chk(err == exp_err, "R10", "error flag", err, exp_err);
    chk(bad_width == 0, "R6", "strobe width violations", bad_width, 0);
    chk(bad_gap == 0, "R7", "gap violations", bad_gap, 0);
    if (o == 1) exp_mem[a[7:0]] = d;
    if (o == 2) exp_mem[a[7:0]] = 8'hFF;
    if (o == 0) chk(rdata == exp_mem[a[7:0]], "R5", "read data", rdata, exp_mem[a[7:0]]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog expired: actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 256; k++) begin mem[k] = 8'hFF; exp_mem[k] = 8'hFF; end
    for (int k = 0; k < 5; k++) begin h_a[k] = '0; h_d[k] = '0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !dq_oe, "R1", "status after reset", {busy, done, err, dq_oe}, 0);
    chk(ce_n && we_n && oe_n, "R1", "strobes after reset", {ce_n, we_n, oe_n}, 3'b111);
    rst_n = 1'b1;
    run_op(3, 12'h000, 8'h00, 0, 0);          // R4
    run_op(0, 12'h123, 8'h00, 0, 0);          // R5 erased byte
    run_op(1, 12'h123, 8'h5A, 3, 0);          // R2, R8
    run_op(0, 12'h123, 8'h00, 0, 0);
    run_op(2, 12'h123, 8'h00, 2, 0);          // R3, R9 with 0x7F status
    run_op(0, 12'h123, 8'h00, 0, 0);
    run_op(1, 12'h0C4, 8'h3C, PMAX - 1, 0);   // R10 last poll succeeds
    run_op(1, 12'h0C5, 8'h81, PMAX, 0);       // R10 timeout
    run_op(2, 12'h0C6, 8'h00, PMAX, 0);       // R10 erase timeout
    run_op(2, 12'h0C6, 8'h00, 0, 1);          // R11 injected request
    run_op(1, 12'h555, 8'h00, 0, 0);
    run_op(0, 12'h555, 8'h00, 0, 1);
    for (int i = 0; i < 30; i++) begin
      int o, br;
      o  = int'($urandom_range(0, 3));
      br = int'($urandom_range(0, PMAX + 1));
      run_op(o, AW'($urandom_range(0, 4095)), 8'($urandom), br, ($urandom_range(0, 3) == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule